// File: doc/BRIEF.md
# Gated Periodic Conversion-Request Timer

This block paces conversion requests towards an ADC sequencer. One free-running prescaler, clocked by the module clock, produces five single-cycle tick strobes at 1/4, 1/16, 1/64, 1/256 and 1/1024 of the clock rate. Every channel picks one of these strobes, or none, and counts it down in an 8-bit counter. On the first selected tick that finds the counter already at zero, the channel emits a one-cycle trigger and raises a pending-request flag.

The flag behaves like the valid half of a handshake, and the conversion-started strobe behaves like the accept half. A raised flag stays up until the sequencer reports that the conversion has started. There is no timeout and no drop: back-pressure from the sequencer only stretches the period. While a request waits, the counter holds at zero and emits no further triggers. The start strobe reloads the counter from the channel's programmed reload value.

Each channel also has a 2-bit mode field and an external gating line. A zero mode or a low gate stops the channel and pins its counter at 4. This gives a fast first request after the gate opens and still filters short glitches on the gate. The prescaler is shared and is never restarted, so the first trigger after a channel starts can be late by up to one selected tick period.

Top module: `conv_req_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every trigger and every request flag is 0. The prescaler count restarts at zero and every counter holds 4.
- R2: Rate select values 1, 2, 3, 4 and 5 pick ticks every 4, 16, 64, 256 and 1024 clocks. The ticks come from one divider that is free-running from reset. Values 0, 6 and 7 give no tick, and such a channel never triggers.
- R3: A running channel decrements once per selected tick while nonzero. A selected tick that finds it at zero produces a one-cycle trigger. When each request is accepted one cycle after it rises, successive triggers are (reload+1) ticks apart.
- R4: A trigger raises the channel's request flag in the next cycle. The flag then stays high until a cycle with the conversion-started strobe, and it is low in the cycle after that strobe unless a new trigger coincides with it.
- R5: After a trigger the counter holds zero and gives no further trigger until the conversion-started strobe arrives. That strobe loads the reload value.
- R6: With mode 2'b00, or with the gate low, the counter is forced to 4 every cycle and no trigger occurs. After a running channel's gate opens, its first trigger comes on the fifth selected tick, which is 16 to 19 clocks later at rate 1.
- R7: A selected tick in the cycle right after the counter has become zero, whether by decrement or by a reload of 0, is not counted.
- R8: The channels are independent apart from the shared tick phase. Each output matches a behavioural per-channel model in every cycle.
- R9: Modes 2'b01, 2'b10 and 2'b11 all run the channel identically.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2*NCH | Per-channel mode; 2'b00 stops the channel |
| rate_i | input | 3*NCH | Per-channel tick select (0 none, 1..5 divide 4..1024) |
| reload_i | input | CW*NCH | Per-channel reload value |
| gate_i | input | NCH | Per-channel gating line, high enables |
| conv_start_i | input | NCH | Conversion-started strobe per channel |
| trig_o | output | NCH | One-cycle trigger event per channel |
| req_o | output | NCH | Pending conversion request per channel |

## Verification
The bench targets the first trigger after the gate opens. A design that reloaded from the reload value instead of presetting 4, or that reset the prescaler, would land outside the 16 to 19 clock window. It also issues a start with a reload of 0 timed just before a tick, and a design that counted the tick right after zero would trigger four clocks early. A held request is left unaccepted for a long stretch, which exposes a design that re-triggers or reloads early. Stopped modes and the unused rate codes are checked for silence, and every cycle is compared with a behavioural model, so a design that leaked state between channels would diverge from it.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int MODE_W     = 2;
  localparam int RATE_W     = 3;
  localparam int NUM_RATES  = 5;
  localparam int RATE_STEP  = 2;   // log2 of ratio between adjacent rates
  localparam int PRESET_VAL = 4;

  typedef logic [MODE_W-1:0] mode_t;
  typedef logic [RATE_W-1:0] rate_t;

  localparam mode_t MODE_OFF = 2'b00;
endpackage

// File: rtl/crt_prescaler.sv
module crt_prescaler #(
  parameter int NRATE = crt_pkg::NUM_RATES,
  parameter int STEP  = crt_pkg::RATE_STEP
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [NRATE-1:0] ticks_o
);
  localparam int DW = NRATE * STEP;

  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  // strobe k fires once every 2^(STEP*(k+1)) clocks
  for (genvar k = 0; k < NRATE; k++) begin : g_tick
    assign ticks_o[k] = &div_q[STEP*(k+1)-1:0];
  end
endmodule

// File: rtl/crt_channel.sv
module crt_channel #(
  parameter int CW    = 8,
  parameter int NRATE = crt_pkg::NUM_RATES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  crt_pkg::mode_t      mode_i,
  input  crt_pkg::rate_t      rate_i,
  input  logic [CW-1:0]       reload_i,
  input  logic                gate_i,
  input  logic                start_i,
  input  logic [NRATE-1:0]    ticks_i,
  output logic                trig_o,
  output logic                req_o
);
  localparam logic [CW-1:0] PRESET = CW'(crt_pkg::PRESET_VAL);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          held_q;    // trigger issued, waiting for start
  logic          fresh_q;   // counter became zero last edge
  logic          req_q;
  logic          run;
  logic          tick_sel;
  logic          at_zero;

  assign run     = (mode_i != crt_pkg::MODE_OFF) && gate_i;
  assign at_zero = (cnt_q == '0);

  always_comb begin
    tick_sel = 1'b0;
    for (int k = 0; k < NRATE; k++) begin
      if (rate_i == crt_pkg::rate_t'(k + 1)) tick_sel = ticks_i[k];
    end
  end

  assign trig_o = run && tick_sel && at_zero && !held_q && !fresh_q;
  assign req_o  = req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= PRESET;
      held_q  <= 1'b0;
      fresh_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      req_q <= trig_o || (req_q && !start_i);
      if (!run) begin
        cnt_q   <= PRESET;
        held_q  <= 1'b0;
        fresh_q <= 1'b0;
      end else if (start_i && held_q) begin
        cnt_q   <= reload_i;
        held_q  <= 1'b0;
        fresh_q <= (reload_i == '0);
      end else if (trig_o) begin
        held_q  <= 1'b1;
        fresh_q <= 1'b0;
      end else if (tick_sel && !at_zero) begin
        cnt_q   <= cnt_q - ONE;
        fresh_q <= (cnt_q == ONE);
      end else begin
        fresh_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/conv_req_timer.sv
module conv_req_timer #(
  parameter int NCH = 4,
  parameter int CW  = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NCH*crt_pkg::MODE_W-1:0]    mode_i,
  input  logic [NCH*crt_pkg::RATE_W-1:0]    rate_i,
  input  logic [NCH*CW-1:0]                 reload_i,
  input  logic [NCH-1:0]                    gate_i,
  input  logic [NCH-1:0]                    conv_start_i,
  output logic [NCH-1:0]                    trig_o,
  output logic [NCH-1:0]                    req_o
);
  localparam int NRATE = crt_pkg::NUM_RATES;
  localparam int MW    = crt_pkg::MODE_W;
  localparam int RW    = crt_pkg::RATE_W;

  logic [NRATE-1:0] ticks;

  crt_prescaler #(.NRATE(NRATE), .STEP(crt_pkg::RATE_STEP)) presc_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ticks_o (ticks)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    crt_channel #(.CW(CW), .NRATE(NRATE)) ch_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_i   (mode_i[c*MW +: MW]),
      .rate_i   (rate_i[c*RW +: RW]),
      .reload_i (reload_i[c*CW +: CW]),
      .gate_i   (gate_i[c]),
      .start_i  (conv_start_i[c]),
      .ticks_i  (ticks),
      .trig_o   (trig_o[c]),
      .req_o    (req_o[c])
    );
  end
endmodule

// File: rtl/crt_chk.sv
module crt_chk #(
  parameter int NCH = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NCH*crt_pkg::MODE_W-1:0] mode_i,
  input logic [NCH*crt_pkg::RATE_W-1:0] rate_i,
  input logic [NCH-1:0]                 gate_i,
  input logic [NCH-1:0]                 conv_start_i,
  input logic [NCH-1:0]                 trig_o,
  input logic [NCH-1:0]                 req_o
);
  localparam int MW = crt_pkg::MODE_W;
  localparam int RW = crt_pkg::RATE_W;

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic stopped;
    logic rate_dead;
    logic waiting_q;

    assign stopped   = (mode_i[c*MW +: MW] == crt_pkg::MODE_OFF) || !gate_i[c];
    assign rate_dead = (rate_i[c*RW +: RW] == 3'd0) || (rate_i[c*RW +: RW] > 3'd5);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       waiting_q <= 1'b0;
      else if (stopped) waiting_q <= 1'b0;
      else              waiting_q <= trig_o[c] || (waiting_q && !conv_start_i[c]);
    end

    // R4
    trig_sets_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o[c] |=> req_o[c]);
    // R4
    req_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o[c] && conv_start_i[c] && !trig_o[c]) |=> !req_o[c]);
    // R4
    req_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_o[c]) |-> $past(trig_o[c]));
    // R5
    no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o[c] |-> !waiting_q);
    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o[c] |=> !trig_o[c]);
    // R6
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stopped |-> !trig_o[c]);
    // R2
    dead_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rate_dead |-> !trig_o[c]);
  end
endmodule

bind conv_req_timer crt_chk #(.NCH(NCH)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode_i       (mode_i),
  .rate_i       (rate_i),
  .gate_i       (gate_i),
  .conv_start_i (conv_start_i),
  .trig_o       (trig_o),
  .req_o        (req_o)
);

// File: tb/conv_req_timer_tb_top.sv
`timescale 1ns/1ps
module conv_req_timer_tb_top;
  localparam int NCH = 4;
  localparam int CW  = 8;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [NCH*2-1:0]     mode_v = '0;
  logic [NCH*3-1:0]     rate_v = '0;
  logic [NCH*CW-1:0]    reload_v = '0;
  logic [NCH-1:0]       gate_v = '0;
  logic [NCH-1:0]       auto_ack = '0;
  logic [NCH-1:0]       man_start = '0;
  logic [NCH-1:0]       conv_start;
  logic [NCH-1:0]       trig;
  logic [NCH-1:0]       req;

  assign conv_start = (auto_ack & req) | man_start;

  always #10 clk = ~clk;   // 50 MHz

  conv_req_timer #(.NCH(NCH), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_v), .rate_i(rate_v),
    .reload_i(reload_v), .gate_i(gate_v), .conv_start_i(conv_start),
    .trig_o(trig), .req_o(req)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int cyc = 0;

  // behavioural model state
  int m_div;
  int m_cnt[NCH];
  bit m_held[NCH];
  bit m_fresh[NCH];
  bit m_req[NCH];
  int trig_cnt[NCH];
  int last_trig[NCH];
  int prev_trig[NCH];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit model_tick(input int r);
    int per;
    if (r < 1 || r > 5) return 0;
    per = 1 << (2 * r);
    return (m_div % per) == per - 1;
  endfunction

  // per-cycle reference comparison (R8), sampled mid low phase
  always begin
    @(negedge clk);
    #5;
    if (!rst_n) begin
      m_div = 0;
      for (int i = 0; i < NCH; i++) begin
        m_cnt[i] = 4; m_held[i] = 0; m_fresh[i] = 0; m_req[i] = 0;
      end
      check(trig == '0 && req == '0, "R1 outputs in reset", int'({trig, req}), 0);
    end else begin
      for (int i = 0; i < NCH; i++) begin
        bit run, tk, st, et;
        run = (mode_v[2*i +: 2] != 2'b00) && gate_v[i];
        tk  = model_tick(int'(rate_v[3*i +: 3]));
        st  = conv_start[i];
        et  = run && tk && (m_cnt[i] == 0) && !m_held[i] && !m_fresh[i];
        check(trig[i] == et, $sformatf("R8 trig ch%0d", i), int'(trig[i]), int'(et));
        check(req[i] == m_req[i], $sformatf("R8 req ch%0d", i), int'(req[i]), int'(m_req[i]));
        if (trig[i]) begin
          trig_cnt[i]++;
          prev_trig[i] = last_trig[i];
          last_trig[i] = cyc;
        end
        m_req[i] = et || (m_req[i] && !st);
        if (!run) begin
          m_cnt[i] = 4; m_held[i] = 0; m_fresh[i] = 0;
        end else if (st && m_held[i]) begin
          m_cnt[i] = int'(reload_v[CW*i +: CW]);
          m_held[i] = 0;
          m_fresh[i] = (m_cnt[i] == 0);
        end else if (et) begin
          m_held[i] = 1; m_fresh[i] = 0;
        end else if (tk && m_cnt[i] > 0) begin
          m_cnt[i] = m_cnt[i] - 1;
          m_fresh[i] = (m_cnt[i] == 0);
        end else begin
          m_fresh[i] = 0;
        end
      end
      m_div = (m_div + 1) % 1024;
    end
    cyc++;
  end

  task automatic wait_trig(input int ch, input int limit);
    int n;
    n = trig_cnt[ch];
    for (int k = 0; k < limit && trig_cnt[ch] == n; k++) @(negedge clk);
    check(trig_cnt[ch] > n, $sformatf("R3 trigger seen ch%0d", ch), trig_cnt[ch], n + 1);
  endtask

  task automatic set_ch(input int ch, input logic [1:0] md, input logic [2:0] rt,
                        input int rl, input bit ack);
    mode_v[2*ch +: 2]     = md;
    rate_v[3*ch +: 3]     = rt;
    reload_v[CW*ch +: CW] = CW'(rl);
    auto_ack[ch]          = ack;
  endtask

  task automatic pulse_start(input int ch, output int s);
    s = cyc;
    man_start[ch] = 1'b1;
    @(negedge clk);
    man_start[ch] = 1'b0;
  endtask

  initial begin
    int g, s, n, d;
    for (int i = 0; i < NCH; i++) begin
      trig_cnt[i] = 0; last_trig[i] = 0; prev_trig[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(trig == '0 && req == '0, "R1 outputs after reset", int'({trig, req}), 0);

    // R6 preset: first trigger on fifth tick after gate opens; R9 mode 01
    set_ch(0, 2'b01, 3'd1, 3, 1);
    g = cyc; gate_v[0] = 1'b1;
    wait_trig(0, 100);
    d = last_trig[0] - g;
    check(d >= 16 && d <= 19, "R6 first trigger after gate open", d, 16);

    // R3 period (reload+1) ticks, rate 1 and rate 2 concurrently (R8)
    set_ch(1, 2'b11, 3'd2, 2, 1); gate_v[1] = 1'b1;
    wait_trig(0, 100); wait_trig(0, 100);
    check(last_trig[0] - prev_trig[0] == 16, "R3 period rate1 reload3",
          last_trig[0] - prev_trig[0], 16);
    wait_trig(1, 300); wait_trig(1, 300);
    check(last_trig[1] - prev_trig[1] == 48, "R3 period rate2 reload2 mode11 R9",
          last_trig[1] - prev_trig[1], 48);

    // R4 / R5 hold without acceptance, mode 10
    set_ch(2, 2'b10, 3'd1, 1, 0); gate_v[2] = 1'b1;
    wait_trig(2, 100);
    check(req[2] == 1'b1, "R4 request raised", int'(req[2]), 1);
    n = trig_cnt[2];
    repeat (100) @(negedge clk);
    check(trig_cnt[2] == n, "R5 no retrigger while held", trig_cnt[2], n);
    check(req[2] == 1'b1, "R4 request held", int'(req[2]), 1);
    pulse_start(2, s);
    check(req[2] == 1'b0, "R4 request cleared after start", int'(req[2]), 0);
    wait_trig(2, 100);
    d = last_trig[2] - s;
    check(d >= 5 && d <= 8, "R5 reload then retrigger", d, 5);

    // R7 ignored tick after reload of zero
    set_ch(3, 2'b01, 3'd1, 0, 0); gate_v[3] = 1'b1;
    wait_trig(3, 100);
    while (m_div % 4 != 2) @(negedge clk);
    pulse_start(3, s);
    wait_trig(3, 100);
    d = last_trig[3] - s;
    check(d == 5, "R7 tick right after zero ignored", d, 5);
    while (m_div % 4 != 0) @(negedge clk);
    pulse_start(3, s);
    wait_trig(3, 100);
    d = last_trig[3] - s;
    check(d == 3, "R7 later tick counted", d, 3);

    // R6 gate low silences, reopen gives preset window again
    gate_v[0] = 1'b0;
    n = trig_cnt[0];
    repeat (60) @(negedge clk);
    check(trig_cnt[0] == n, "R6 no trigger while gated off", trig_cnt[0], n);
    g = cyc; gate_v[0] = 1'b1;
    wait_trig(0, 100);
    d = last_trig[0] - g;
    check(d >= 16 && d <= 19, "R6 preset after regating", d, 16);

    // R6 mode off
    set_ch(1, 2'b00, 3'd2, 2, 1);
    n = trig_cnt[1];
    repeat (200) @(negedge clk);
    check(trig_cnt[1] == n, "R6 mode off silent", trig_cnt[1], n);

    // R2 dead rate codes
    for (int r = 0; r < 8; r += 6) begin
      set_ch(1, 2'b01, 3'(r), 0, 1);
      n = trig_cnt[1];
      repeat (150) @(negedge clk);
      check(trig_cnt[1] == n, $sformatf("R2 rate code %0d silent", r), trig_cnt[1], n);
    end
    set_ch(1, 2'b01, 3'd7, 0, 1);
    n = trig_cnt[1];
    repeat (150) @(negedge clk);
    check(trig_cnt[1] == n, "R2 rate code 7 silent", trig_cnt[1], n);

    // R2 slowest rate, reload 0
    set_ch(1, 2'b01, 3'd5, 0, 1);
    wait_trig(1, 6000); wait_trig(1, 1200);
    check(last_trig[1] - prev_trig[1] == 1024, "R2 rate5 period",
          last_trig[1] - prev_trig[1], 1024);

    // R2 rate 4, reload 1
    set_ch(0, 2'b01, 3'd4, 1, 1);
    wait_trig(0, 2000); wait_trig(0, 600);
    check(last_trig[0] - prev_trig[0] == 512, "R2 rate4 period",
          last_trig[0] - prev_trig[0], 512);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired, run hung");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule